// File: doc/BRIEF.md
# Bidirectional Pin Port with Emulation Routing

This block is an eight-pin general-purpose I/O port. It holds two registers on a small register bus: a data latch and a direction mask. For each pin, the direction bit chooses between two roles. With the bit set, the pin is an output driven from the data latch. With the bit clear, the pin is a high-impedance input. Input pins reach the read path only through a two-flop synchronizer clocked by the bus clock.

A read of the data register is assembled bit by bit. Output pins return the latched bit and input pins return the synchronized pin level. A read of the direction register returns its contents.

When the emulation input is high, the read path ignores the internal values and returns whatever the external bus presents. Writes in that mode still update the internal registers. Each such write is also mirrored onto the external bus as a one-cycle strobe that carries the data and the register select. Pad buffers are outside this block; it hands them an output value and an output enable per pin.

Top module: `bidir_io_port`

## Requirements
- R1: After reset, the data latch and the direction mask both hold 0x00. As a result, `pinOe` is 0x00, `pinOut` is 0x00, and both register reads return 0x00 while the pins are low.
- R2: Bit i of `pinOe` equals direction bit i (1 = output, 0 = input). `pinOut` always carries the data latch.
- R3: Outside emulation, a read with `busSel`=0 (data register) returns, for each bit i, data bit i where direction bit i is 1 and synchronized pin i where it is 0.
- R4: Outside emulation, a read with `busSel`=1 (direction register) returns the direction mask unchanged.
- R5: A write (`busWr`=1) loads `busWrData` into the register chosen by `busSel` on the next rising edge. A read in the same cycle still shows the old value. Writes are accepted at every cycle, with no lock.
- R6: A change on `pinIn` reaches a data-register read of an input bit after exactly two rising edges. It is not visible after one edge.
- R7: While `emuMode` is 1, `busRdData` equals `extRdData` for either value of `busSel`.
- R8: While `emuMode` is 1, a write still updates the internal register. In the same cycle it raises `extWrStb`, with `extWrData`=`busWrData` and `extWrSel`=`busSel`. `extWrStb` stays 0 outside emulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| emuMode | input | 1 | Emulation routing enable |
| busSel | input | 1 | Register select: 0 data latch, 1 direction mask |
| busWr | input | 1 | Write strobe for the selected register |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data of the selected register |
| extRdData | input | 8 | External bus data returned on reads in emulation |
| extWrStb | output | 1 | Mirrored write strobe toward the external bus |
| extWrSel | output | 1 | Register select carried with the mirrored write |
| extWrData | output | 8 | Data carried with the mirrored write |
| pinIn | input | 8 | Pin levels from the pads |
| pinOut | output | 8 | Output levels toward the pads |
| pinOe | output | 8 | Per-pin output enable |

## Verification
Three timing rules apply, and the bench samples each result where it is due:
- Register writes appear on the outputs half a cycle after the rising edge that takes them. The bench also samples before that edge, to confirm the old value is still read during the write cycle.
- Pin changes are applied at a falling edge and sampled after the first and after the second rising edge. This confirms the two-edge synchronizer latency exactly.
- Emulation reads and the mirrored write strobe are combinational. They are checked one time step after the inputs change, in the same cycle.

The bench sweeps all 256 direction masks against data and pin patterns computed in the bench itself.

// File: rtl/bidir_io_pkg.sv
package bidir_io_pkg;
  typedef struct packed {
    logic datWe;
    logic dirWe;
    logic rdDir;
    logic rdExt;
  } ioStrobe_t;
endpackage

// File: rtl/bidir_io_ctrl.sv
module bidir_io_ctrl
  import bidir_io_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             emuMode,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [WIDTH-1:0] busWrData,
  output ioStrobe_t        strobe,
  output logic             extWrStb,
  output logic             extWrSel,
  output logic [WIDTH-1:0] extWrData
);
  // Internal write enables do not depend on emulation: writes always land.
  always_comb begin
    strobe.datWe = busWr & ~busSel;
    strobe.dirWe = busWr & busSel;
    strobe.rdDir = busSel;
    strobe.rdExt = emuMode;
  end

  // Mirror toward the external bus only in emulation.
  assign extWrStb  = busWr & emuMode;
  assign extWrSel  = busSel;
  assign extWrData = busWrData;
endmodule

// File: rtl/bidir_io_dpath.sv
module bidir_io_dpath
  import bidir_io_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ioStrobe_t        strobe,
  input  logic [WIDTH-1:0] busWrData,
  input  logic [WIDTH-1:0] extRdData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] busRdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] datReg;
  logic [WIDTH-1:0] dirReg;
  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncChain;
  logic [WIDTH-1:0] datView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      datReg <= '0;
      dirReg <= '0;
    end else begin
      if (strobe.datWe) datReg <= busWrData;
      if (strobe.dirWe) dirReg <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
    end else begin
      for (int s = LAST; s > 0; s--) syncChain[s] <= syncChain[s-1];
      syncChain[0] <= pinIn;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign datView[b] = dirReg[b] ? datReg[b] : syncChain[LAST][b];
  end

  always_comb begin
    if (strobe.rdExt)      busRdData = extRdData;
    else if (strobe.rdDir) busRdData = dirReg;
    else                   busRdData = datView;
  end

  assign pinOut = datReg;
  assign pinOe  = dirReg;
endmodule

// File: rtl/bidir_io_port.sv
module bidir_io_port
  import bidir_io_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             emuMode,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [WIDTH-1:0] busWrData,
  output logic [WIDTH-1:0] busRdData,
  input  logic [WIDTH-1:0] extRdData,
  output logic             extWrStb,
  output logic             extWrSel,
  output logic [WIDTH-1:0] extWrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);
  ioStrobe_t strobe;

  bidir_io_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .emuMode   (emuMode),
    .busSel    (busSel),
    .busWr     (busWr),
    .busWrData (busWrData),
    .strobe    (strobe),
    .extWrStb  (extWrStb),
    .extWrSel  (extWrSel),
    .extWrData (extWrData)
  );

  bidir_io_dpath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .extRdData (extRdData),
    .pinIn     (pinIn),
    .busRdData (busRdData),
    .pinOut    (pinOut),
    .pinOe     (pinOe)
  );
endmodule

// File: rtl/bidir_io_port_chk.sv
module bidir_io_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             emuMode,
  input logic             busSel,
  input logic             busWr,
  input logic [WIDTH-1:0] busWrData,
  input logic [WIDTH-1:0] busRdData,
  input logic [WIDTH-1:0] extRdData,
  input logic             extWrStb,
  input logic             extWrSel,
  input logic [WIDTH-1:0] extWrData,
  input logic [WIDTH-1:0] pinOut,
  input logic [WIDTH-1:0] pinOe
);
  AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (pinOe == '0 && pinOut == '0)); // R1
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel) |=> pinOe == $past(busWrData)); // R2
  AST_DAT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busSel) |=> pinOut == $past(busWrData)); // R5
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> ($stable(pinOe) && $stable(pinOut))); // R5
  AST_DIR_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!emuMode && busSel) |-> busRdData == pinOe); // R4
  AST_EMU_READ: assert property (@(posedge clk) disable iff (!rstN)
    emuMode |-> busRdData == extRdData); // R7
  AST_EXT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !emuMode |-> !extWrStb); // R8
  AST_EXT_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    extWrStb |-> (extWrData == busWrData && extWrSel == busSel && busWr)); // R8
endmodule

bind bidir_io_port bidir_io_port_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/bidir_io_port_tb.sv
module bidir_io_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       emuMode = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [7:0] extRdData = '0;
  logic       extWrStb;
  logic       extWrSel;
  logic [7:0] extWrData;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut;
  logic [7:0] pinOe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bidir_io_port u_dut (
    .clk(clk), .rstN(rstN), .emuMode(emuMode), .busSel(busSel), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .extRdData(extRdData),
    .extWrStb(extWrStb), .extWrSel(extWrSel), .extWrData(extWrData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Drive a write at a falling edge; it lands on the following rising edge.
  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    busSel = sel; busWr = 1'b1; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    busSel = sel;
    #1 v = busRdData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] dat;
    logic [7:0] pin;
    logic [7:0] expDat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pinOe", pinOe, 8'h00);
    chk("R1 pinOut", pinOut, 8'h00);
    rd(1'b0, v); chk("R1 data read", v, 8'h00);
    rd(1'b1, v); chk("R1 dir read", v, 8'h00);

    // R5 same-cycle read returns old value, next edge loads
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busWrData = 8'hC3;
    #1 chk("R5 old value during write", busRdData, 8'h00);
    @(negedge clk);
    busWr = 1'b0;
    #1 chk("R5 loaded after edge", busRdData, 8'hC3);
    wr(1'b1, 8'h00);

    // R6 synchronizer latency on input pins
    @(negedge clk);
    pinIn = 8'hA5; busSel = 1'b0;
    #1 chk("R6 before any edge", busRdData, 8'h00);
    @(negedge clk);
    #1 chk("R6 after one edge", busRdData, 8'h00);
    @(negedge clk);
    #1 chk("R6 after two edges", busRdData, 8'hA5);

    // R2 R3 R4 sweep over every direction mask
    for (int m = 0; m < 256; m++) begin
      dat = 8'(m * 37 + 11);
      pin = 8'(m * 113) ^ 8'h5A;
      wr(1'b1, 8'(m));
      wr(1'b0, dat);
      pinIn = pin;
      repeat (2) @(negedge clk);
      expDat = (8'(m) & dat) | (~8'(m) & pin);
      chk("R2 pinOe", pinOe, 8'(m));
      chk("R2 pinOut", pinOut, dat);
      rd(1'b0, v); chk("R3 data read mux", v, expDat);
      rd(1'b1, v); chk("R4 dir read", v, 8'(m));
    end

    // R8 outside emulation no mirrored strobe
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b1; busWrData = 8'h11;
    #1 chk("R8 no strobe outside emu", {7'd0, extWrStb}, 8'h00);
    @(negedge clk);
    busWr = 1'b0;

    // R7 emulation reads come from external bus
    wr(1'b1, 8'hFF);
    emuMode = 1'b1; extRdData = 8'h3C;
    rd(1'b0, v); chk("R7 emu data read", v, 8'h3C);
    rd(1'b1, v); chk("R7 emu dir read", v, 8'h3C);
    extRdData = 8'h81;
    rd(1'b0, v); chk("R7 emu data read 2", v, 8'h81);

    // R8 emulation write mirrored and still stored
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b1; busWrData = 8'h5A;
    #1;
    chk("R8 strobe", {7'd0, extWrStb}, 8'h01);
    chk("R8 data", extWrData, 8'h5A);
    chk("R8 select", {7'd0, extWrSel}, 8'h00);
    @(negedge clk);
    busSel = 1'b1; busWrData = 8'hF0;
    #1;
    chk("R8 select dir", {7'd0, extWrSel}, 8'h01);
    chk("R8 data dir", extWrData, 8'hF0);
    @(negedge clk);
    busWr = 1'b0;
    #1 chk("R8 strobe drops", {7'd0, extWrStb}, 8'h00);
    emuMode = 1'b0;
    rd(1'b1, v); chk("R8 dir stored", v, 8'hF0);
    chk("R8 data stored", pinOut, 8'h5A);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule